// File: doc/BRIEF.md
# Coprocessor Busy-Wait Handshake Responder

This block sits on the coprocessor side of a pipelined processor's coprocessor interface. On every cycle in which the core marks the instruction in its decode stage as valid, the responder compares the instruction's coprocessor-number field with its own configured number. If the number does not match, it leaves both active-low response lines high ("not mine"). If the number matches, it claims the instruction. When the local datapath can begin at once, it reports "accepted and ready" by pulling both lines low. Otherwise it reports "accepted but busy" by pulling only line A low, and that stalls the core.

While the block stalls the core, it waits for its local ready input and also watches the core's abandon line. The core raises abandon when an enabled fast or normal interrupt cuts the wait short. A ready input drives line B low, and the instruction then starts. An abandon releases both lines and drops the instruction. The responder gates all architectural change through a commit-enable pulse. This pulse is raised only in the cycle in which execution really begins, so nothing done during the wait can leave a trace.

Top module: `cp_busy_responder`

## Requirements
- R1: A synchronous active-high reset makes resp_a_n = 1, resp_b_n = 1 and commit_en = 0 on the cycle after the reset edge.
- R2: When idle, a decode strobe whose dec_cpnum differs from MY_CPN (default 5), or no strobe at all, leaves resp_a_n = resp_b_n = 1 on the next cycle.
- R3: When idle, a strobe with a matching number while unit_ready = 1 gives resp_a_n = 0 and resp_b_n = 0 on the next cycle, for exactly one cycle, followed by both lines high.
- R4: When idle, a strobe with a matching number while unit_ready = 0 gives resp_a_n = 0 and resp_b_n = 1 (busy-wait) on the next cycle. This state holds for as long as unit_ready and core_abandon stay 0.
- R5: During busy-wait, unit_ready = 1 with core_abandon = 0 gives resp_a_n = resp_b_n = 0 on the next cycle, for one cycle.
- R6: During busy-wait, core_abandon = 1 returns both lines high on the next cycle. Abandon takes priority over a unit_ready that arrives in the same cycle.
- R7: commit_en is 1 exactly in the cycles where both response lines are low, never two cycles running, and never for an abandoned instruction.
- R8: core_abandon while idle has no effect. Decode strobes that arrive during busy-wait or during the execute cycle are not claimed; the block returns to idle (both lines high) after the instruction it holds.
- R9: resp_b_n is never low while resp_a_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage holds a valid coprocessor instruction |
| dec_cpnum | input | CPN_W | Coprocessor-number field of that instruction |
| unit_ready | input | 1 | Local datapath can begin execution |
| core_abandon | input | 1 | Core abandons the busy-waited instruction |
| resp_a_n | output | 1 | Response line A, active low: instruction claimed |
| resp_b_n | output | 1 | Response line B, active low: execution starts |
| commit_en | output | 1 | One-cycle enable for architectural state update |

## Verification
The assertions assume that the core raises core_abandon only in answer to a busy-wait response. They also assume that all inputs are stable around the rising edge. The stimulus meets both conditions by changing every input on the falling edge. The bench still raises abandon while the block is idle and during strobes, and it expects no effect in either case. The assertions take no view on the timing of unit_ready, so the stimulus varies how long the wait lasts. It also presents ready and abandon in the same cycle.

// File: rtl/cp_busy_responder.sv
module cp_busy_responder #(
  parameter int CPN_W = 4,
  parameter logic [CPN_W-1:0] MY_CPN = CPN_W'(5)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic [CPN_W-1:0] dec_cpnum,
  input  logic             unit_ready,
  input  logic             core_abandon,
  output logic             resp_a_n,
  output logic             resp_b_n,
  output logic             commit_en
);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_EXEC} st_t;
  st_t st, st_nx;

  wire claim = dec_valid && (dec_cpnum == MY_CPN);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (claim) st_nx = unit_ready ? S_EXEC : S_BUSY;
      S_BUSY: if (core_abandon) st_nx = S_IDLE;
              else if (unit_ready) st_nx = S_EXEC;
      S_EXEC: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk)
    if (rst) st <= S_IDLE;
    else     st <= st_nx;

  assign resp_a_n  = (st == S_IDLE);
  assign resp_b_n  = (st != S_EXEC);
  assign commit_en = (st == S_EXEC);

  wire idle_o = resp_a_n && resp_b_n;
  wire busy_o = !resp_a_n && resp_b_n;
  wire exec_o = !resp_a_n && !resp_b_n;

  a_r1_reset: assert property (@(posedge clk)
    rst |=> resp_a_n && resp_b_n && !commit_en);
  a_r2_foreign: assert property (@(posedge clk) disable iff (rst)
    idle_o && !(dec_valid && dec_cpnum == MY_CPN) |=> idle_o);
  a_r3_ready_now: assert property (@(posedge clk) disable iff (rst)
    idle_o && dec_valid && dec_cpnum == MY_CPN && unit_ready |=> exec_o ##1 idle_o);
  a_r4_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (idle_o && dec_valid && dec_cpnum == MY_CPN && !unit_ready) ||
    (busy_o && !unit_ready && !core_abandon) |=> busy_o);
  a_r5_start: assert property (@(posedge clk) disable iff (rst)
    busy_o && unit_ready && !core_abandon |=> exec_o);
  a_r6_abandon: assert property (@(posedge clk) disable iff (rst)
    busy_o && core_abandon |=> idle_o && !commit_en);
  a_r7_commit_once: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> !commit_en);
  a_r7_commit_match: assert property (@(posedge clk) disable iff (rst)
    commit_en == exec_o);
  a_r8_exec_ends: assert property (@(posedge clk) disable iff (rst)
    exec_o |=> idle_o);
  a_r9_b_needs_a: assert property (@(posedge clk) disable iff (rst)
    !resp_b_n |-> !resp_a_n);

endmodule

// File: tb/test_cp_busy_responder.sv
module test_cp_busy_responder;
  logic clk = 0, rst = 1, dec_valid = 0, unit_ready = 0, core_abandon = 0;
  logic [3:0] dec_cpnum = 0;
  logic resp_a_n, resp_b_n, commit_en;
  int checks = 0, errors = 0, commits = 0;

  always #2 clk = ~clk;

  cp_busy_responder #(.CPN_W(4), .MY_CPN(4'd5)) i_cp_busy_responder (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_cpnum(dec_cpnum),
    .unit_ready(unit_ready), .core_abandon(core_abandon),
    .resp_a_n(resp_a_n), .resp_b_n(resp_b_n), .commit_en(commit_en));

  always @(negedge clk) if (commit_en) commits++;

  task automatic chk(string req, logic ea, logic eb, logic ec);
    checks++;
    if ({resp_a_n, resp_b_n, commit_en} !== {ea, eb, ec}) begin
      errors++;
      $display("FAIL %s: a/b/commit = %b%b%b expected %b%b%b", req,
               resp_a_n, resp_b_n, commit_en, ea, eb, ec);
    end
  endtask

  task automatic chk_cnt(string req, int exp);
    checks++;
    if (commits !== exp) begin
      errors++;
      $display("FAIL %s: commit count %0d expected %0d", req, commits, exp);
    end
  endtask

  task automatic drive(logic v, logic [3:0] n, logic rdy, logic ab);
    dec_valid = v; dec_cpnum = n; unit_ready = rdy; core_abandon = ab;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1; drive(1, 5, 1, 0); chk("R1", 1, 1, 0);
    drive(1, 5, 0, 0); chk("R1", 1, 1, 0);
    rst = 0; drive(0, 0, 0, 0); chk("R1", 1, 1, 0);
  endtask

  task automatic t_foreign;
    drive(1, 4, 1, 0); chk("R2", 1, 1, 0);
    drive(1, 13, 0, 0); chk("R2", 1, 1, 0);
    drive(0, 5, 1, 0); chk("R2", 1, 1, 0);
  endtask

  task automatic t_ready_now;
    int c0 = commits;
    drive(1, 5, 1, 0); chk("R3", 0, 0, 1);
    drive(0, 0, 0, 0); chk("R3", 1, 1, 0);
    chk_cnt("R7", c0 + 1);
  endtask

  task automatic t_busy_ready(int waits);
    int c0 = commits;
    drive(1, 5, 0, 0); chk("R4", 0, 1, 0);
    for (int i = 0; i < waits; i++) begin drive(0, 0, 0, 0); chk("R4", 0, 1, 0); end
    drive(0, 0, 1, 0); chk("R5", 0, 0, 1);
    drive(0, 0, 1, 0); chk("R5", 1, 1, 0);
    chk_cnt("R7", c0 + 1);
  endtask

  task automatic t_abandon(logic rdy_too);
    int c0 = commits;
    drive(1, 5, 0, 0); chk("R4", 0, 1, 0);
    drive(0, 0, 0, 0); chk("R4", 0, 1, 0);
    drive(0, 0, rdy_too, 1); chk("R6", 1, 1, 0);
    drive(0, 0, 1, 0); chk("R6", 1, 1, 0);
    chk_cnt("R7", c0);
  endtask

  task automatic t_idle_abandon;
    drive(0, 0, 1, 1); chk("R8", 1, 1, 0);
    drive(1, 5, 1, 1); chk("R8", 0, 0, 1);
    drive(0, 0, 0, 0); chk("R8", 1, 1, 0);
  endtask

  task automatic t_strobe_inside;
    drive(1, 5, 0, 0); chk("R4", 0, 1, 0);
    drive(1, 5, 0, 0); chk("R8", 0, 1, 0);
    drive(1, 5, 1, 0); chk("R8", 0, 0, 1);
    drive(1, 5, 1, 0); chk("R8", 1, 1, 0);
    drive(0, 0, 0, 0); chk("R9", 1, 1, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_foreign();
    t_ready_now();
    t_busy_ready(0);
    t_busy_ready(5);
    t_abandon(0);
    t_abandon(1);
    t_idle_abandon();
    t_strobe_inside();
    t_ready_now();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule